// File: doc/BRIEF.md
# Command Packet Register-Write Decoder

The decoder accepts a stream of 32-bit command words on a valid/ready input. Each packet is one header word followed by its payload. The block turns each packet into single-cycle register writes, each carrying an address, a data word and a strobe. It handles four packet kinds:

- a burst write to consecutive registers, or repeatedly to one register;
- a write to two independent registers;
- an empty filler packet;
- a drawing packet, whose rectangle and copy lists are expanded into coordinate register writes with their 16-bit halves exchanged.

Burst packets are held back until the register sink reports enough free entries for the whole burst. Drawing packets with an opcode the block does not know produce no writes. Their payload is consumed and dropped, and an error strobe marks them.

Header layout:

| Bits | Field |
|------|-------|
| 31:30 | Packet kind |
| 29:16 | Length field: payload words minus one |
| 15 | Same-register flag |
| 14:0 | Burst register index |
| 10:0 | First index of a two-register packet |
| 21:11 | Second index of a two-register packet |
| 7:0 | Drawing opcode |

Register indices count 32-bit words, so each index becomes a byte address when shifted left by two.

Top module: `cmd_pkt_decoder`

## Requirements
- R1: A header with kind 2 produces no write and has no payload; the next accepted word is decoded as a header.
- R2: A kind 0 header with length field N is followed by N+1 data words; they are written to (idx<<2), (idx<<2)+4, ... in arrival order.
- R3: When header bit 15 is set in a kind 0 packet, every data word of that burst is written to the single byte address idx<<2.
- R4: After a kind 0 header, cmd_ready_o stays low and no write occurs until sink_free_i is at least N+1; at exactly N+1 the burst proceeds.
- R5: A kind 1 header takes two data words and writes the first to (bits 10:0)<<2 and the second to (bits 21:11)<<2.
- R6: In a drawing packet the first payload word is a settings word. Its option words follow it in a fixed order, each only when enabled:
  - the source pitch word, when settings bit 0 is set, goes to 0x0200;
  - the destination pitch word, when settings bit 1 is set, goes to 0x0204;
  - the brush colour word, when settings bits 7:4 equal 0xD, goes to 0x0208.
  
  All option words are written unchanged.
- R7: With opcode 0x21, the remaining payload words alternate between 0x0214 and 0x0218, starting with 0x0214, each written with its upper and lower 16-bit halves exchanged.
- R8: With opcode 0x22, the remaining payload words cycle through 0x0210, 0x0214 and 0x0218, each written with its halves exchanged.
- R9: A drawing packet with any other opcode writes nothing and consumes its N+1 payload words. err_o is high for exactly the one cycle after its header is accepted.
- R10: Out of reset, cmd_ready_o is high and wr_valid_o and err_o are low. Each write appears on wr_valid_o, wr_addr_o and wr_data_o for one cycle, in the cycle after the word that causes it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_data_i | input | 32 | Command word |
| cmd_ready_o | output | 1 | Decoder accepts a word this cycle |
| sink_free_i | input | FREE_W (8) | Free entries reported by the register sink |
| wr_valid_o | output | 1 | Register write strobe |
| wr_addr_o | output | ADDR_W (18) | Byte address of the write |
| wr_data_o | output | 32 | Write data |
| err_o | output | 1 | Unsupported drawing opcode seen |

## Verification
The bench builds the decoder with its default parameters:

- an 18-bit address, which leaves room for the full 15-bit burst index shifted by two;
- an 8-bit free-entry count.

With these defaults the bench can drive sink_free_i just below, exactly at, and well above a burst's length. Drawing packets are exercised with every option word enabled, and again with a brush field one code away from the solid value. A packet with an unknown opcode is followed directly by another packet, which shows that the decoder returns to header decoding on the correct word.

// File: rtl/cmd_pkt_pkg.sv
package cmd_pkt_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 14;
  localparam int IDX_W  = 15;
  localparam int PIDX_W = 11;
  localparam int OP_W   = 8;
  localparam int REM_W  = CNT_W + 1;

  typedef enum logic [1:0] {PT_BURST, PT_PAIR, PT_NOP, PT_DRAW} ptype_e;
  typedef enum logic [2:0] {S_HDR, S_WAIT, S_BURST, S_PAIR, S_SET, S_DRAW, S_SKIP} state_e;

  typedef struct packed {
    ptype_e              ptype;
    logic [CNT_W-1:0]    count;
    logic                one_reg;
    logic [IDX_W-1:0]    idx;
    logic [PIDX_W-1:0]   idx_a;
    logic [PIDX_W-1:0]   idx_b;
    logic [OP_W-1:0]     opcode;
  } hdr_t;

  localparam logic [OP_W-1:0] OP_PAINT    = 8'h21;
  localparam logic [OP_W-1:0] OP_BLIT     = 8'h22;
  localparam logic [3:0]      BRUSH_SOLID = 4'hD;
endpackage

// File: rtl/pkt_hdr_decode.sv
module pkt_hdr_decode
  import cmd_pkt_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output hdr_t              hdr_o,
  output logic              draw_ok_o,
  output logic              draw_blit_o
);
  always_comb begin
    hdr_o.ptype   = ptype_e'(word_i[31:30]);
    hdr_o.count   = word_i[29:16];
    hdr_o.one_reg = word_i[15];
    hdr_o.idx     = word_i[14:0];
    hdr_o.idx_a   = word_i[10:0];
    hdr_o.idx_b   = word_i[21:11];
    hdr_o.opcode  = word_i[7:0];
  end

  assign draw_blit_o = (hdr_o.opcode == OP_BLIT);
  assign draw_ok_o   = draw_blit_o || (hdr_o.opcode == OP_PAINT);
endmodule

// File: rtl/draw_expand.sv
module draw_expand
  import cmd_pkt_pkg::*;
#(
  parameter int                ADDR_W      = 18,
  parameter logic [ADDR_W-1:0] SRC_PITCH_A = 'h0200,
  parameter logic [ADDR_W-1:0] DST_PITCH_A = 'h0204,
  parameter logic [ADDR_W-1:0] BRUSH_FG_A  = 'h0208,
  parameter logic [ADDR_W-1:0] SRC_YX_A    = 'h0210,
  parameter logic [ADDR_W-1:0] DST_YX_A    = 'h0214,
  parameter logic [ADDR_W-1:0] DST_HW_A    = 'h0218
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_ld_i,
  input  logic              set_src_i,
  input  logic              set_dst_i,
  input  logic              set_solid_i,
  input  logic              blit_i,
  input  logic              step_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int HALF = WORD_W / 2;

  logic       pend_src_q, pend_dst_q, pend_brush_q;
  logic [1:0] slot_q;
  logic [1:0] slot_last;

  assign slot_last = blit_i ? 2'd2 : 2'd1;

  always_comb begin
    data_o = {data_i[HALF-1:0], data_i[WORD_W-1:HALF]};
    addr_o = DST_YX_A;
    if (pend_src_q) begin
      addr_o = SRC_PITCH_A;
      data_o = data_i;
    end else if (pend_dst_q) begin
      addr_o = DST_PITCH_A;
      data_o = data_i;
    end else if (pend_brush_q) begin
      addr_o = BRUSH_FG_A;
      data_o = data_i;
    end else if (blit_i) begin
      unique case (slot_q)
        2'd0:    addr_o = SRC_YX_A;
        2'd1:    addr_o = DST_YX_A;
        default: addr_o = DST_HW_A;
      endcase
    end else begin
      addr_o = (slot_q == 2'd0) ? DST_YX_A : DST_HW_A;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_src_q   <= 1'b0;
      pend_dst_q   <= 1'b0;
      pend_brush_q <= 1'b0;
      slot_q       <= '0;
    end else if (set_ld_i) begin
      pend_src_q   <= set_src_i;
      pend_dst_q   <= set_dst_i;
      pend_brush_q <= set_solid_i;
      slot_q       <= '0;
    end else if (step_i) begin
      if (pend_src_q)        pend_src_q   <= 1'b0;
      else if (pend_dst_q)   pend_dst_q   <= 1'b0;
      else if (pend_brush_q) pend_brush_q <= 1'b0;
      else                   slot_q <= (slot_q >= slot_last) ? 2'd0 : slot_q + 2'd1;
    end
  end

  // R6: option words drain strictly in source, destination, brush order
  a_r6_opt_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !set_ld_i && pend_src_q) |=> (pend_dst_q == $past(pend_dst_q)) && !pend_src_q);
endmodule

// File: rtl/wr_out_reg.sv
module wr_out_reg
  import cmd_pkt_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              err_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      err_o      <= 1'b0;
    end else begin
      wr_valid_o <= wr_en_i;
      err_o      <= err_i;
      if (wr_en_i) begin
        wr_addr_o <= wr_addr_i;
        wr_data_o <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/cmd_pkt_decoder.sv
module cmd_pkt_decoder
  import cmd_pkt_pkg::*;
#(
  parameter int                ADDR_W      = 18,
  parameter int                FREE_W      = 8,
  parameter logic [ADDR_W-1:0] SRC_PITCH_A = 'h0200,
  parameter logic [ADDR_W-1:0] DST_PITCH_A = 'h0204,
  parameter logic [ADDR_W-1:0] BRUSH_FG_A  = 'h0208,
  parameter logic [ADDR_W-1:0] SRC_YX_A    = 'h0210,
  parameter logic [ADDR_W-1:0] DST_YX_A    = 'h0214,
  parameter logic [ADDR_W-1:0] DST_HW_A    = 'h0218
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_data_i,
  output logic              cmd_ready_o,
  input  logic [FREE_W-1:0] sink_free_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic              err_o
);
  localparam int CMP_W = REM_W + FREE_W;

  state_e            state_q, state_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr2_q, addr2_d;
  logic              one_q, one_d, blit_q, blit_d;

  hdr_t              hdr;
  logic              draw_ok, draw_blit;
  logic              accept, last, room;
  logic              wr_en, err_d, set_ld, drw_step;
  logic [ADDR_W-1:0] wr_a, drw_addr;
  logic [31:0]       wr_d, drw_data;

  pkt_hdr_decode u_hdr (
    .word_i      (cmd_data_i),
    .hdr_o       (hdr),
    .draw_ok_o   (draw_ok),
    .draw_blit_o (draw_blit)
  );

  draw_expand #(
    .ADDR_W(ADDR_W), .SRC_PITCH_A(SRC_PITCH_A), .DST_PITCH_A(DST_PITCH_A),
    .BRUSH_FG_A(BRUSH_FG_A), .SRC_YX_A(SRC_YX_A), .DST_YX_A(DST_YX_A), .DST_HW_A(DST_HW_A)
  ) u_draw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_ld_i    (set_ld),
    .set_src_i   (cmd_data_i[0]),
    .set_dst_i   (cmd_data_i[1]),
    .set_solid_i (cmd_data_i[7:4] == BRUSH_SOLID),
    .blit_i      (blit_q),
    .step_i      (drw_step),
    .data_i      (cmd_data_i),
    .addr_o      (drw_addr),
    .data_o      (drw_data)
  );

  wr_out_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_a),
    .wr_data_i  (wr_d),
    .err_i      (err_d),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .err_o      (err_o)
  );

  assign cmd_ready_o = (state_q != S_WAIT);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign last        = (rem_q == REM_W'(1));
  assign room        = {{REM_W{1'b0}}, sink_free_i} >= {{FREE_W{1'b0}}, rem_q};

  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    addr_d   = addr_q;
    addr2_d  = addr2_q;
    one_d    = one_q;
    blit_d   = blit_q;
    wr_en    = 1'b0;
    wr_a     = addr_q;
    wr_d     = cmd_data_i;
    err_d    = 1'b0;
    set_ld   = 1'b0;
    drw_step = 1'b0;
    unique case (state_q)
      S_HDR: if (accept) begin
        unique case (hdr.ptype)
          PT_BURST: begin
            addr_d  = ADDR_W'({hdr.idx, 2'b00});
            one_d   = hdr.one_reg;
            rem_d   = {1'b0, hdr.count} + REM_W'(1);
            state_d = S_WAIT;
          end
          PT_PAIR: begin
            addr_d  = ADDR_W'({hdr.idx_a, 2'b00});
            addr2_d = ADDR_W'({hdr.idx_b, 2'b00});
            rem_d   = REM_W'(2);
            state_d = S_PAIR;
          end
          PT_NOP: ;
          default: begin
            rem_d = {1'b0, hdr.count} + REM_W'(1);
            if (draw_ok) begin
              blit_d  = draw_blit;
              state_d = S_SET;
            end else begin
              err_d   = 1'b1;
              state_d = S_SKIP;
            end
          end
        endcase
      end
      S_WAIT: if (room) state_d = S_BURST;
      S_BURST: if (accept) begin
        wr_en = 1'b1;
        if (!one_q) addr_d = addr_q + ADDR_W'(4);
      end
      S_PAIR: if (accept) begin
        wr_en  = 1'b1;
        addr_d = addr2_q;
      end
      S_SET:  if (accept) set_ld = 1'b1;
      S_DRAW: if (accept) begin
        wr_en    = 1'b1;
        wr_a     = drw_addr;
        wr_d     = drw_data;
        drw_step = 1'b1;
      end
      default: ;
    endcase
    if (accept && state_q != S_HDR) begin
      rem_d = rem_q - REM_W'(1);
      if (last)                 state_d = S_HDR;
      else if (state_q == S_SET) state_d = S_DRAW;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HDR;
      rem_q   <= '0;
      addr_q  <= '0;
      addr2_q <= '0;
      one_q   <= 1'b0;
      blit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      addr_q  <= addr_d;
      addr2_q <= addr2_d;
      one_q   <= one_d;
      blit_q  <= blit_d;
    end
  end

  // R10: a write strobe always follows an accepted word
  a_r10_wr_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(cmd_valid_i && cmd_ready_o));

  // R1: a header word never produces a write
  a_r1_hdr_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HDR && cmd_valid_i) |=> !wr_valid_o);

  // R4: burst starts only when the sink had room for all of it
  a_r4_room_before_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && state_d == S_BURST) |-> (CMP_W'(sink_free_i) >= CMP_W'(rem_q)));

  // R9: error strobe lasts one cycle and carries no write
  a_r9_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r9_err_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !wr_valid_o);
endmodule

// File: tb/tb_cmd_pkt_decoder.sv
`timescale 1ns/1ps
module tb_cmd_pkt_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready;
  logic [7:0]  sink_free = 8'd255;
  logic        wr_valid;
  logic [17:0] wr_addr;
  logic [31:0] wr_data;
  logic        err;

  int checks = 0, errors = 0, err_seen = 0;
  bit done = 0;
  logic [49:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  cmd_pkt_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data),
    .cmd_ready_o(cmd_ready), .sink_free_i(sink_free), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] swp(input logic [31:0] w);
    return {w[15:0], w[31:16]};
  endfunction

  task automatic expect_wr(input logic [17:0] a, input logic [31:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  // drive one word, return at the negedge after its acceptance
  task automatic push(input logic [31:0] w);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = 32'hDEAD_BEEF;
  endtask

  function automatic logic [31:0] h_burst(input int n, input bit one, input int idx);
    return (32'(n) << 16) | (32'(one) << 15) | 32'(idx);
  endfunction
  function automatic logic [31:0] h_pair(input int a, input int b);
    return (32'd1 << 30) | (32'(b) << 11) | 32'(a);
  endfunction
  function automatic logic [31:0] h_draw(input int n, input int op);
    return (32'd3 << 30) | (32'(n) << 16) | 32'(op);
  endfunction

  // reference compare on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected write", {14'd0, wr_addr, wr_data}, 64'd0);
        end else begin
          logic [49:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({wr_addr, wr_data} === e, t, {14'd0, wr_addr, wr_data}, {14'd0, e});
        end
      end
      if (err) err_seen++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready === 1'b1, "R10 reset ready", 64'(cmd_ready), 64'd1);
    chk(wr_valid === 1'b0, "R10 reset wr_valid", 64'(wr_valid), 64'd0);
    chk(err === 1'b0, "R10 reset err", 64'(err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 incrementing burst
    for (int i = 0; i < 4; i++) expect_wr(18'h100 + 18'(4*i), 32'hA000_0000 + 32'(i), "R2 burst");
    push(h_burst(3, 0, 'h40));
    for (int i = 0; i < 4; i++) begin
      push(32'hA000_0000 + 32'(i));
      chk(wr_valid === 1'b1, "R10 write next cycle", 64'(wr_valid), 64'd1);
    end

    // R3 same-register burst, top index
    for (int i = 0; i < 3; i++) expect_wr(18'h1FFFC, 32'hB0 + 32'(i), "R3 one-reg");
    push(h_burst(2, 1, 'h7FFF));
    for (int i = 0; i < 3; i++) push(32'hB0 + 32'(i));

    // R4 wait for room: 5 words, free 3 then 4 then exactly 5
    sink_free = 8'd3;
    push(h_burst(4, 0, 'h8));
    for (int i = 0; i < 6; i++) begin
      if (i == 3) sink_free = 8'd4;
      chk(cmd_ready === 1'b0, "R4 stalled ready", 64'(cmd_ready), 64'd0);
      chk(wr_valid === 1'b0, "R4 stalled no write", 64'(wr_valid), 64'd0);
      @(negedge clk);
    end
    sink_free = 8'd5;
    for (int i = 0; i < 5; i++) expect_wr(18'h20 + 18'(4*i), 32'hC0 + 32'(i), "R4 burst after room");
    for (int i = 0; i < 5; i++) push(32'hC0 + 32'(i));
    sink_free = 8'd255;

    // R5 two-register packet
    expect_wr(18'h014, 32'h1111_2222, "R5 first reg");
    expect_wr(18'h148C, 32'h3333_4444, "R5 second reg");
    push(h_pair('h005, 'h523));
    push(32'h1111_2222);
    push(32'h3333_4444);

    // R1 no-ops, then a pair decoded as header
    push(32'h8000_0000);
    push(32'hBFFF_FFFF);
    chk(wr_valid === 1'b0, "R1 nop no write", 64'(wr_valid), 64'd0);
    expect_wr(18'h4, 32'h55, "R1 header after nop");
    expect_wr(18'h8, 32'h66, "R1 header after nop");
    push(h_pair(1, 2));
    push(32'h55);
    push(32'h66);

    // R6 + R7 paint with all options
    expect_wr(18'h200, 32'h0000_0A0A, "R6 src pitch");
    expect_wr(18'h204, 32'h0000_0B0B, "R6 dst pitch");
    expect_wr(18'h208, 32'h00FF_0000, "R6 brush");
    expect_wr(18'h214, swp(32'h0001_0002), "R7 dst yx");
    expect_wr(18'h218, swp(32'h0003_0004), "R7 dst hw");
    expect_wr(18'h214, swp(32'h0005_0006), "R7 dst yx");
    expect_wr(18'h218, swp(32'h0007_0008), "R7 dst hw");
    push(h_draw(7, 'h21));
    push(32'h0000_00D3);
    push(32'h0000_0A0A);
    push(32'h0000_0B0B);
    push(32'h00FF_0000);
    push(32'h0001_0002);
    push(32'h0003_0004);
    push(32'h0005_0006);
    push(32'h0007_0008);

    // R6 + R8 blit, dst pitch only, brush field 0xC is not solid
    expect_wr(18'h204, 32'h0000_1234, "R6 dst pitch only");
    for (int i = 0; i < 2; i++) begin
      expect_wr(18'h210, swp(32'h1000_0001 + 32'(i)), "R8 src yx");
      expect_wr(18'h214, swp(32'h2000_0001 + 32'(i)), "R8 dst yx");
      expect_wr(18'h218, swp(32'h3000_0001 + 32'(i)), "R8 dst hw");
    end
    push(h_draw(7, 'h22));
    push(32'h0000_00C2);
    push(32'h0000_1234);
    for (int i = 0; i < 2; i++) begin
      push(32'h1000_0001 + 32'(i));
      push(32'h2000_0001 + 32'(i));
      push(32'h3000_0001 + 32'(i));
    end

    // R9 unsupported opcode, payload skipped, error pulse
    push(h_draw(2, 'h33));
    chk(err === 1'b1, "R9 err after header", 64'(err), 64'd1);
    push(32'h0000_00F3);
    chk(err === 1'b0, "R9 err one cycle", 64'(err), 64'd0);
    push(32'h4000_0000);
    push(32'h8000_0000);
    chk(wr_valid === 1'b0, "R9 no write", 64'(wr_valid), 64'd0);
    expect_wr(18'hC, 32'h77, "R9 next packet");
    expect_wr(18'h10, 32'h88, "R9 next packet");
    push(h_pair(3, 4));
    push(32'h77);
    push(32'h88);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all writes seen", 64'(exp_q.size()), 64'd0);
    chk(err_seen == 1, "R9 error count", 64'(err_seen), 64'd1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule